// File: doc/BRIEF.md
# Modulator Clock Divider

This block generates the clock that drives an external sigma-delta modulator. On each cycle of the system clock it looks at one of two tick-enable inputs and counts the ticks of the selected input. From that count it produces a divided square wave. An 8-bit divide setting N gives an output period of N+1 source ticks. A setting of zero turns the output off. A global enable gates the whole divider: while it is low the output is held low and the counter is cleared.

Along with the clock level, the block emits a one-cycle strobe on each rising transition and on each falling transition of the output. A serial receiver that samples on the internally generated clock uses these strobes, so it does not need to detect the edges of the output itself.

The divide setting and the source select are latched only while the global enable is low. Writes made while the divider runs have no effect until the next time it is disabled.

Top module: `modclk_divider`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `mclk_o`, `rise_o` and `fall_o` are all 0.
- R2: With the global enable high and a divide setting N from 1 to 255, `mclk_o` repeats every N+1 selected ticks. The period therefore ranges from 2 to 256 ticks.
- R3: Within each period the output is high for ceil((N+1)/2) ticks and low for the remaining ticks.
- R4: A divide setting of 0 holds `mclk_o` low and produces no strobes, even while the global enable is high.
- R5: The first selected tick after the global enable rises drives `mclk_o` high, and that tick starts a new period.
- R6: One system clock cycle after the global enable is sampled low, `mclk_o` is 0.
- R7: A source select of 0 counts `sys_tick_i`. A source select of 1 counts `alt_tick_i`. The output changes only on cycles in which the selected tick input is 1.
- R8: Changes to the divide setting or the source select made while the global enable is high do not affect the output.
- R9: `rise_o` is 1 for exactly the cycle in which `mclk_o` has just gone from 0 to 1. `fall_o` is 1 for exactly the cycle in which it has just gone from 1 to 0. The two strobes are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en_i | input | 1 | Global enable for the divider |
| div_i | input | 8 | Divide setting N; the period is N+1 ticks, and 0 turns the output off |
| src_sel_i | input | 1 | Tick source select: 0 selects the system tick, 1 the alternate tick |
| sys_tick_i | input | 1 | Tick enable derived from the system clock |
| alt_tick_i | input | 1 | Tick enable derived from the alternate (audio) clock |
| mclk_o | output | 1 | Divided modulator clock |
| rise_o | output | 1 | One-cycle strobe on a 0 to 1 transition of `mclk_o` |
| fall_o | output | 1 | One-cycle strobe on a 1 to 0 transition of `mclk_o` |

## Verification
A corrupted phase counter appears on `mclk_o` within one period, which is at most 256 ticks. It shows up as a high or low run of the wrong length, or as a first level after enable that is not high. A latched configuration that wrongly follows its inputs while the divider runs changes the run lengths on the very next tick after the write. A broken disable path leaves `mclk_o` high in the cycle that should be low, with no `fall_o` strobe. The bench compares all three outputs against an independent tick-counting model on every cycle, so any such fault is reported in the cycle where it first appears.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    parameter int MCG_DIV_W = 8;
    localparam int MCG_CNT_W = MCG_DIV_W + 1;

    typedef struct packed {
        logic [MCG_DIV_W-1:0] div;
        logic                 src;
    } mcg_cfg_t;

    typedef enum logic [0:0] {
        SRC_SYS = 1'b0,
        SRC_ALT = 1'b1
    } mcg_src_e;

    // Length of the high phase: ceil((div+1)/2) == (div+2)/2
    function automatic logic [MCG_CNT_W-1:0] high_len(input logic [MCG_DIV_W-1:0] div);
        logic [MCG_CNT_W:0] sum;
        sum = {2'b00, div} + 2;
        return sum[MCG_CNT_W:1];
    endfunction

endpackage

// File: rtl/mcg_cfg_shadow.sv
module mcg_cfg_shadow
    import mcg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_i,
    input  mcg_cfg_t cfg_i,
    output mcg_cfg_t cfg_o
);

    mcg_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (!en_i) begin
            cfg_q <= cfg_i;
        end
    end

    assign cfg_o = cfg_q;

    // R8: the latched setting is frozen while the divider runs
    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        $past(en_i) |-> $stable(cfg_q));

endmodule

// File: rtl/mcg_tick_mux.sv
module mcg_tick_mux
    import mcg_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic             sel_i,
    input  logic [N_SRC-1:0] ticks_i,
    output logic             tick_o
);

    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [SEL_W-1:0] idx;

    generate
        if (N_SRC == 1) begin : g_single
            assign idx    = '0;
            assign tick_o = ticks_i[0];
        end else begin : g_multi
            assign idx    = SEL_W'(sel_i);
            assign tick_o = ticks_i[idx];
        end
    endgenerate

endmodule

// File: rtl/mcg_phase_ctr.sv
module mcg_phase_ctr
    import mcg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_i,
    input  logic                 tick_i,
    input  logic [MCG_DIV_W-1:0] div_i,
    output logic                 out_q_o,
    output logic                 out_nxt_o
);

    logic [MCG_DIV_W-1:0] cnt_q, cnt_d;
    logic                 run_q, run_d;
    logic                 out_q, out_d;
    logic [MCG_CNT_W-1:0] hi_len;

    assign hi_len = high_len(div_i);

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        out_d = out_q;
        if (!en_i || div_i == '0) begin
            cnt_d = '0;
            run_d = 1'b0;
            out_d = 1'b0;
        end else if (tick_i) begin
            if (!run_q) begin
                run_d = 1'b1;
                cnt_d = '0;
            end else if (cnt_q == div_i) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
            out_d = ({1'b0, cnt_d} < hi_len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
            out_q <= out_d;
        end
    end

    assign out_q_o   = out_q;
    assign out_nxt_o = out_d;

    // R4: a zero setting keeps the clock low
    assert_zero_div_low_R4: assert property (@(posedge clk) disable iff (rst)
        (div_i == '0) |=> !out_q);

    // R7: without a selected tick the level does not move while enabled
    assert_no_tick_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (en_i && div_i != '0 && !tick_i) |=> $stable(out_q));

    // R5: the first tick after start raises the clock
    assert_start_high_R5: assert property (@(posedge clk) disable iff (rst)
        (en_i && div_i != '0 && tick_i && !run_q) |=> out_q);

endmodule

// File: rtl/mcg_edge_strobe.sv
module mcg_edge_strobe (
    input  logic clk,
    input  logic rst,
    input  logic cur_i,
    input  logic nxt_i,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    logic rise_q, fall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= nxt_i & ~cur_i;
            fall_q <= ~nxt_i & cur_i;
        end
    end

    assign rise_o = rise_q;
    assign fall_o = fall_q;

    // R9: the strobes track the registered level seen at the output
    assert_rise_match_R9: assert property (@(posedge clk) disable iff (rst)
        rise_q |-> (lvl_i && !$past(lvl_i)));
    assert_fall_match_R9: assert property (@(posedge clk) disable iff (rst)
        fall_q |-> (!lvl_i && $past(lvl_i)));
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(rise_q && fall_q));

endmodule

// File: rtl/modclk_divider.sv
module modclk_divider
    import mcg_pkg::*;
#(
    parameter int DIV_W = MCG_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             glb_en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             src_sel_i,
    input  logic             sys_tick_i,
    input  logic             alt_tick_i,
    output logic             mclk_o,
    output logic             rise_o,
    output logic             fall_o
);

    localparam int N_SRC = 2;

    mcg_cfg_t         cfg_in, cfg_lat;
    logic [N_SRC-1:0] ticks;
    logic             tick_sel;
    logic             lvl_q, lvl_nxt;

    assign cfg_in.div = MCG_DIV_W'(div_i);
    assign cfg_in.src = src_sel_i;
    assign ticks      = {alt_tick_i, sys_tick_i};

    mcg_cfg_shadow u_shadow (
        .clk   (clk),
        .rst   (rst),
        .en_i  (glb_en_i),
        .cfg_i (cfg_in),
        .cfg_o (cfg_lat)
    );

    mcg_tick_mux #(.N_SRC(N_SRC)) u_mux (
        .sel_i   (cfg_lat.src),
        .ticks_i (ticks),
        .tick_o  (tick_sel)
    );

    mcg_phase_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .en_i      (glb_en_i),
        .tick_i    (tick_sel),
        .div_i     (cfg_lat.div),
        .out_q_o   (lvl_q),
        .out_nxt_o (lvl_nxt)
    );

    mcg_edge_strobe u_strobe (
        .clk    (clk),
        .rst    (rst),
        .cur_i  (lvl_q),
        .nxt_i  (lvl_nxt),
        .lvl_i  (lvl_q),
        .rise_o (rise_o),
        .fall_o (fall_o)
    );

    assign mclk_o = lvl_q;

    // R6: clearing the global enable drops the clock on the next cycle
    assert_disable_low_R6: assert property (@(posedge clk) disable iff (rst)
        !glb_en_i |=> !mclk_o);

    // R1: outputs are quiet right after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!mclk_o && !rise_o && !fall_o));

endmodule

// File: tb/modclk_divider_tb.sv
module modclk_divider_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       glb_en;
    logic [7:0] div;
    logic       src;
    logic       sys_t;
    logic       alt_t;
    logic       mclk, rise, fall;

    int total = 0;
    int bad   = 0;

    // reference model state
    int  m_n;
    bit  m_src;
    bit  m_run;
    int  m_k;
    bit  m_out;

    always #2 clk = ~clk;

    modclk_divider u_dut (
        .clk        (clk),
        .rst        (rst),
        .glb_en_i   (glb_en),
        .div_i      (div),
        .src_sel_i  (src),
        .sys_tick_i (sys_t),
        .alt_tick_i (alt_t),
        .mclk_o     (mclk),
        .rise_o     (rise),
        .fall_o     (fall)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive, advance the model on the edge, compare after it
    task automatic step(input bit en, input int d, input bit s,
                        input bit st, input bit at, input string req);
        bit prev, tk;
        logic [2:0] act, exp;
        glb_en = en; div = 8'(d); src = s; sys_t = st; alt_t = at;
        @(posedge clk);
        #1;
        prev = m_out;
        tk = m_src ? at : st;
        if (!en || m_n == 0) begin
            m_run = 0; m_k = 0; m_out = 0;
        end else if (tk) begin
            if (!m_run) begin m_run = 1; m_k = 0; end
            else if (m_k == m_n) m_k = 0;
            else m_k++;
            m_out = (m_k < (m_n + 2) / 2);
        end
        if (!en) begin m_n = d; m_src = s; end
        exp = {m_out, m_out & ~prev, ~m_out & prev};
        act = {mclk, rise, fall};
        check(act === exp, req, act, exp);
    endtask

    task automatic t_reset();
        rst = 1; glb_en = 0; div = 8'd3; src = 0; sys_t = 1; alt_t = 0;
        m_n = 0; m_src = 0; m_run = 0; m_k = 0; m_out = 0;
        repeat (3) @(posedge clk);
        #1;
        check({mclk, rise, fall} === 3'b000, "R1", {mclk, rise, fall}, 0);
        rst = 0;
        @(posedge clk);
        #1;
        check({mclk, rise, fall} === 3'b000, "R1", {mclk, rise, fall}, 0);
        m_n = 3;
    endtask

    // R2 R3 R5 R9: run on the system tick, then R6 on disable
    task automatic t_run_sys(input int n, input int cycles, input string req);
        repeat (2) step(0, n, 0, 1, 0, "R6");
        for (int i = 0; i < cycles; i++) step(1, n, 0, 1, 0, req);
        step(0, n, 0, 1, 0, "R6");
        step(0, n, 0, 1, 0, "R6");
    endtask

    // R7: alternate tick source, with sys ticks that must be ignored
    task automatic t_run_alt(input int n, input int cycles);
        repeat (2) step(0, n, 1, 1, 0, "R7");
        for (int i = 0; i < cycles; i++) step(1, n, 1, 1, (i % 3) == 1, "R7");
        step(0, n, 1, 0, 0, "R6");
    endtask

    // R4: zero setting keeps the clock low
    task automatic t_zero();
        repeat (2) step(0, 0, 0, 1, 0, "R4");
        for (int i = 0; i < 20; i++) step(1, 0, 0, 1, 1, "R4");
        step(0, 0, 0, 1, 0, "R4");
    endtask

    // R8: settings written while running are ignored
    task automatic t_hold();
        repeat (2) step(0, 3, 0, 1, 0, "R8");
        for (int i = 0; i < 6; i++) step(1, 3, 0, 1, 0, "R8");
        for (int i = 0; i < 24; i++) step(1, 9, 1, 1, 0, "R8");
        step(0, 9, 1, 1, 0, "R6");
        step(0, 9, 1, 1, 0, "R6");
    endtask

    // R6: disable while high, mid-period, then re-enable restarts high (R5)
    task automatic t_disable_mid();
        repeat (2) step(0, 7, 0, 1, 0, "R6");
        step(1, 7, 0, 1, 0, "R5");
        step(1, 7, 0, 1, 0, "R6");
        step(0, 7, 0, 1, 0, "R6");
        step(1, 7, 0, 0, 0, "R5");
        step(1, 7, 0, 1, 0, "R5");
        for (int i = 0; i < 10; i++) step(1, 7, 0, 1, 0, "R3");
        step(0, 7, 0, 1, 0, "R6");
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_run_sys(1, 12, "R2");
        t_run_sys(4, 23, "R3");
        t_run_sys(5, 20, "R3");
        t_run_sys(255, 600, "R2");
        t_run_alt(2, 40);
        t_zero();
        t_hold();
        t_disable_mid();
        t_run_sys(2, 10, "R9");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule